// File: doc/BRIEF.md
# Buffered 8-bit PWM timer

This block produces a pulse width modulated output from an 8-bit up-counter. The counter advances on enable strobes from a selectable source: one of several power-of-two divisions of the system clock, a slow-clock strobe, or every second slow strobe. Each period is 256 ticks long. A timer flip-flop toggles once when the count equals the active duty value and once more when the counter wraps. The output pin carries the inverse of that flip-flop. Every wrap also raises a one-cycle overflow interrupt pulse.

Software writes the duty value through a write strobe. While the timer runs, the write is held in a pending register and takes effect at the next wrap. While the timer is stopped, the write takes effect at once. The read port always shows the value in use, not the pending one. Stopping the timer freezes the output level. While stopped, software can force the flip-flop to a chosen level.

A two-state machine sets the operating phase. It has two states: `ST_STOPPED` and `ST_RUNNING`. There are two transitions:
- START, taken when `run` is high in `ST_STOPPED`. It clears the counter and the prescaler.
- HALT, taken when `run` is low in `ST_RUNNING`. It freezes the flip-flop.

Top module: `pwm8_timer`

## Requirements
- R1: After reset the block is in `ST_STOPPED`, `pwm_out` is 1 (flip-flop 0), `ovf_irq` is 0 and `duty_rdata` is 0.
- R2: While running, the counter steps through 0..255 once per source tick. A wrap occurs on the tick taken at count 255. `ovf_irq` is high for exactly one clock, the clock after that tick, so consecutive pulses are 256 ticks apart.
- R3: The flip-flop toggles on the tick at which the count equals the active duty D, and again at the wrap. Measured from an interrupt cycle, `pwm_out` is high for (D+1) ticks of each period. For D = 255 both toggles coincide and cancel, so the output does not change.
- R4: `src_sel` picks the tick source. Codes 0, 1, 2 and 3 tick every 1, 2, 4 and 8 clocks. Code 4 ticks on each `slow_tick` strobe. Code 5 ticks on every second `slow_tick` strobe. Codes 6 and 7 give no ticks.
- R5: A duty write while running goes to a pending register. That value becomes active in the wrap cycle that follows.
- R6: A duty write while stopped becomes active at the next clock edge.
- R7: `duty_rdata` always returns the active duty value. A pending write is not visible on it before the wrap that applies it.
- R8: A duty write sampled in the same clock as a wrap tick is the value made active by that wrap. It replaces any older pending value.
- R9: In `ST_STOPPED` the output holds its level and no interrupt is raised. START clears counter and prescaler, so the first interrupt comes 256×div+1 clocks after the clock in which `run` is raised, where div is the tick spacing in clocks.
- R10: `ff_force_wr` sets the flip-flop to `ff_force_val` while stopped, so `pwm_out` shows the inverse. It has no effect while running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | 1 = run the timer, 0 = stop it |
| src_sel | input | 3 | Tick source select (see R4) |
| slow_tick | input | 1 | One-clock strobe from the slow clock domain, already synchronised |
| duty_wr | input | 1 | Duty write strobe |
| duty_wdata | input | 8 | Duty value to write |
| duty_rdata | output | 8 | Active duty value |
| ff_force_wr | input | 1 | Force strobe for the timer flip-flop (stopped only) |
| ff_force_val | input | 1 | Level forced into the flip-flop |
| pwm_out | output | 1 | Inverted timer flip-flop |
| ovf_irq | output | 1 | One-clock pulse per counter wrap |

## Verification
The main function is tried with duty values 0, mid-range and 255, paired with every tick source including both slow sources. The width of the high time separates the compare toggle from the wrap toggle. The exact interrupt spacing separates one prescaler tap from another. Duty writes are placed in three positions: just after an interrupt, exactly in a wrap cycle, and while stopped. These placements separate shadowed, colliding and immediate loading, and the read-back shows which value is active at each point. A stop in mid-period followed by a restart on a slower tap shows the output holding its level and the prescaler restarting cleanly.

// File: rtl/pwm8_pkg.sv
package pwm8_pkg;
    typedef enum logic {
        ST_STOPPED = 1'b0,
        ST_RUNNING = 1'b1
    } run_state_e;
endpackage

// File: rtl/pwm8_prescaler.sv
module pwm8_prescaler #(
    parameter int N_MAIN_TAPS = 4,
    parameter int SEL_W       = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [SEL_W-1:0] sel,
    input  logic             slow_tick,
    output logic             tick
);
    localparam int PRE_W = (N_MAIN_TAPS > 1) ? N_MAIN_TAPS - 1 : 1;
    localparam logic [SEL_W-1:0] SEL_SLOW  = SEL_W'(N_MAIN_TAPS);
    localparam logic [SEL_W-1:0] SEL_SLOW2 = SEL_W'(N_MAIN_TAPS + 1);

    logic [PRE_W-1:0]       presc;
    logic                   slow_half;
    logic [N_MAIN_TAPS-1:0] tap_tick;

    // tap k strobes once every 2**k clocks
    genvar g;
    generate
        for (g = 0; g < N_MAIN_TAPS; g++) begin : g_tap
            if (g == 0) begin : g_div1
                assign tap_tick[g] = 1'b1;
            end else begin : g_divn
                assign tap_tick[g] = &presc[g-1:0];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            presc     <= '0;
            slow_half <= 1'b0;
        end else begin
            presc <= presc + PRE_W'(1);
            if (slow_tick) slow_half <= ~slow_half;
        end
    end

    always_comb begin
        tick = 1'b0;
        for (int k = 0; k < N_MAIN_TAPS; k++) begin
            if (sel == SEL_W'(k)) tick = tap_tick[k];
        end
        if (sel == SEL_SLOW)  tick = slow_tick;
        if (sel == SEL_SLOW2) tick = slow_tick & slow_half;
        if (!en)              tick = 1'b0;
    end
endmodule

// File: rtl/pwm8_duty_buf.sv
module pwm8_duty_buf #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         running,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         ovf,
    output logic [W-1:0] active
);
    logic [W-1:0] pend;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= '0;
            pend   <= '0;
        end else begin
            if (wr) pend <= wdata;
            if (!running) begin
                if (wr) active <= wdata;
            end else if (ovf) begin
                // a write in the wrap cycle wins over the older pending value
                active <= wr ? wdata : pend;
            end
        end
    end
endmodule

// File: rtl/pwm8_wave.sv
module pwm8_wave #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         running,
    input  logic         tick,
    input  logic [W-1:0] duty,
    input  logic         force_wr,
    input  logic         force_val,
    output logic         ff,
    output logic         ovf,
    output logic         ovf_irq
);
    localparam logic [W-1:0] CNT_MAX = '1;

    logic [W-1:0] cnt;
    logic         match;

    assign ovf   = running && tick && (cnt == CNT_MAX);
    assign match = running && tick && (cnt == duty);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            ff      <= 1'b0;
            ovf_irq <= 1'b0;
        end else begin
            ovf_irq <= ovf;
            if (!running) begin
                cnt <= '0;
                if (force_wr) ff <= force_val;
            end else begin
                if (tick) cnt <= ovf ? '0 : cnt + W'(1);
                ff <= ff ^ match ^ ovf;
            end
        end
    end
endmodule

// File: rtl/pwm8_timer.sv
module pwm8_timer #(
    parameter int CNT_W       = 8,
    parameter int N_MAIN_TAPS = 4,
    parameter int SEL_W       = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] src_sel,
    input  logic             slow_tick,
    input  logic             duty_wr,
    input  logic [CNT_W-1:0] duty_wdata,
    output logic [CNT_W-1:0] duty_rdata,
    input  logic             ff_force_wr,
    input  logic             ff_force_val,
    output logic             pwm_out,
    output logic             ovf_irq
);
    import pwm8_pkg::*;

    run_state_e state, state_nx;
    logic       running;
    logic       tick;
    logic       ovf;
    logic       ff;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_STOPPED;
        else        state <= state_nx;
    end

    // transitions: START and HALT
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_STOPPED: if (run)  state_nx = ST_RUNNING;
            ST_RUNNING: if (!run) state_nx = ST_STOPPED;
        endcase
    end

    // state outputs
    always_comb begin
        unique case (state)
            ST_STOPPED: running = 1'b0;
            ST_RUNNING: running = 1'b1;
        endcase
    end

    pwm8_prescaler #(.N_MAIN_TAPS(N_MAIN_TAPS), .SEL_W(SEL_W)) u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (running),
        .sel       (src_sel),
        .slow_tick (slow_tick),
        .tick      (tick)
    );

    pwm8_duty_buf #(.W(CNT_W)) u_duty (
        .clk     (clk),
        .rst_n   (rst_n),
        .running (running),
        .wr      (duty_wr),
        .wdata   (duty_wdata),
        .ovf     (ovf),
        .active  (duty_rdata)
    );

    pwm8_wave #(.W(CNT_W)) u_wave (
        .clk       (clk),
        .rst_n     (rst_n),
        .running   (running),
        .tick      (tick),
        .duty      (duty_rdata),
        .force_wr  (ff_force_wr),
        .force_val (ff_force_val),
        .ff        (ff),
        .ovf       (ovf),
        .ovf_irq   (ovf_irq)
    );

    assign pwm_out = ~ff;
endmodule

// File: rtl/pwm8_timer_chk.sv
module pwm8_timer_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             running,
    input logic             ovf,
    input logic             duty_wr,
    input logic [CNT_W-1:0] duty_wdata,
    input logic [CNT_W-1:0] duty_rdata,
    input logic             ff_force_wr,
    input logic             ff_force_val,
    input logic             pwm_out,
    input logic             ovf_irq
);
    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_irq |=> !ovf_irq); // R2

    AST_IRQ_ONLY_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_irq |-> $past(running)); // R9

    AST_SHADOW_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
        (running && duty_wr && !ovf) |=> $stable(duty_rdata)); // R7

    AST_WRAP_LOADS_NEW: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && duty_wr) |=> (duty_rdata == $past(duty_wdata))); // R8

    AST_STOPPED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && duty_wr) |=> (duty_rdata == $past(duty_wdata))); // R6

    AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && $past(!running) && !$past(ff_force_wr)) |-> $stable(pwm_out)); // R9

    AST_FORCE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && ff_force_wr) |=> (pwm_out == !$past(ff_force_val))); // R10
endmodule

bind pwm8_timer pwm8_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .running      (running),
    .ovf          (ovf),
    .duty_wr      (duty_wr),
    .duty_wdata   (duty_wdata),
    .duty_rdata   (duty_rdata),
    .ff_force_wr  (ff_force_wr),
    .ff_force_val (ff_force_val),
    .pwm_out      (pwm_out),
    .ovf_irq      (ovf_irq)
);

// File: tb/pwm8_timer_tb_top.sv
`timescale 1ns/1ps
module pwm8_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run = 1'b0;
    logic [2:0] src_sel = 3'd0;
    logic       slow_tick;
    logic       duty_wr = 1'b0;
    logic [7:0] duty_wdata = 8'd0;
    logic [7:0] duty_rdata;
    logic       ff_force_wr = 1'b0;
    logic       ff_force_val = 1'b0;
    logic       pwm_out;
    logic       ovf_irq;

    int total = 0;
    int fails = 0;
    logic [2:0] slow_cnt = 3'd0;

    always #5 clk = ~clk;

    // slow strobe: one clock in every five
    always @(posedge clk) slow_cnt <= (slow_cnt == 3'd4) ? 3'd0 : slow_cnt + 3'd1;
    assign slow_tick = (slow_cnt == 3'd4);

    pwm8_timer dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .run          (run),
        .src_sel      (src_sel),
        .slow_tick    (slow_tick),
        .duty_wr      (duty_wr),
        .duty_wdata   (duty_wdata),
        .duty_rdata   (duty_rdata),
        .ff_force_wr  (ff_force_wr),
        .ff_force_val (ff_force_val),
        .pwm_out      (pwm_out),
        .ovf_irq      (ovf_irq)
    );

    // {src_sel, duty, clocks per tick}
    localparam int NVEC = 8;
    localparam int VEC [NVEC][3] = '{
        '{0,   0,  1}, '{0, 128,  1}, '{1,  64,  2}, '{2, 200,  4},
        '{3,  10,  8}, '{4,  50,  5}, '{5,   3, 10}, '{0, 255,  1}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic write_duty(input logic [7:0] v);
        duty_wr = 1'b1; duty_wdata = v;
        @(negedge clk);
        duty_wr = 1'b0;
    endtask

    task automatic force_ff(input logic v);
        ff_force_wr = 1'b1; ff_force_val = v;
        @(negedge clk);
        ff_force_wr = 1'b0;
    endtask

    task automatic wait_irq(input int maxn, output int n);
        n = 0;
        while (!ovf_irq && n < maxn) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        int n, high, extra, prev, changes;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(pwm_out == 1'b1, "R1 pwm_out", pwm_out, 1);
        chk(ovf_irq == 1'b0, "R1 ovf_irq", ovf_irq, 0);
        chk(duty_rdata == 8'd0, "R1 duty_rdata", duty_rdata, 0);

        // vector table: R2 R3 R4 R6
        for (int v = 0; v < NVEC; v++) begin
            int per;
            per = 256 * VEC[v][2];
            run = 1'b0;
            repeat (2) @(negedge clk);
            src_sel = 3'(VEC[v][0]);
            force_ff(1'b0);
            write_duty(8'(VEC[v][1]));
            chk(duty_rdata == 8'(VEC[v][1]), "R6 stopped write", duty_rdata, VEC[v][1]);
            run = 1'b1;
            wait_irq(2 * per + 20, n);
            chk(ovf_irq == 1'b1, "R4 first irq", ovf_irq, 1);
            high = 0; extra = 0;
            for (int i = 0; i < per; i++) begin
                if (pwm_out) high++;
                if (i > 0 && ovf_irq) extra++;
                @(negedge clk);
            end
            chk(extra == 0, "R2 single-cycle irq", extra, 0);
            chk(ovf_irq == 1'b1, "R2 R4 period", ovf_irq, 1);
            chk(high == ((VEC[v][1] == 255) ? per : (VEC[v][1] + 1) * VEC[v][2]),
                "R3 high time", high,
                (VEC[v][1] == 255) ? per : (VEC[v][1] + 1) * VEC[v][2]);
        end

        // R5 R7 shadowed write while running
        run = 1'b0;
        repeat (2) @(negedge clk);
        src_sel = 3'd0;
        force_ff(1'b0);
        write_duty(8'd20);
        run = 1'b1;
        wait_irq(600, n);
        write_duty(8'd100);
        chk(duty_rdata == 8'd20, "R7 pending hidden", duty_rdata, 20);
        wait_irq(600, n);
        chk(duty_rdata == 8'd100, "R5 applied at wrap", duty_rdata, 100);
        high = 0;
        for (int i = 0; i < 256; i++) begin
            if (pwm_out) high++;
            @(negedge clk);
        end
        chk(high == 101, "R5 new duty high time", high, 101);

        // R8 write in the wrap cycle beats an older pending value
        write_duty(8'd40);
        repeat (254) @(negedge clk);
        write_duty(8'd77);
        chk(ovf_irq == 1'b1, "R8 wrap alignment", ovf_irq, 1);
        chk(duty_rdata == 8'd77, "R8 collision value", duty_rdata, 77);

        // R9 stop mid-period holds the level
        repeat (99) @(negedge clk);
        run = 1'b0;
        @(negedge clk);
        prev = pwm_out; changes = 0; extra = 0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (pwm_out != prev) changes++;
            if (ovf_irq) extra++;
        end
        chk(prev == 0, "R9 level at stop", prev, 0);
        chk(changes == 0, "R9 output held", changes, 0);
        chk(extra == 0, "R9 no irq stopped", extra, 0);
        chk(duty_rdata == 8'd77, "R7 read while stopped", duty_rdata, 77);

        // R10 force while stopped
        force_ff(1'b1);
        chk(pwm_out == 1'b0, "R10 force 1", pwm_out, 0);
        force_ff(1'b0);
        chk(pwm_out == 1'b1, "R10 force 0", pwm_out, 1);

        // R9 restart on the divide-by-4 tap gives a full first period
        src_sel = 3'd2;
        run = 1'b1;
        wait_irq(3000, n);
        chk(n == 1025, "R9 first period length", n, 1025);

        // R10 force ignored while running (output high for 312 clocks here)
        force_ff(1'b1);
        chk(pwm_out == 1'b1, "R10 force ignored", pwm_out, 1);
        repeat (5) @(negedge clk);
        chk(pwm_out == 1'b1, "R10 force ignored later", pwm_out, 1);

        // R4 reserved select codes give no ticks
        run = 1'b0;
        repeat (2) @(negedge clk);
        src_sel = 3'd6;
        run = 1'b1;
        prev = pwm_out; changes = 0; extra = 0;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (pwm_out != prev) changes++;
            if (ovf_irq) extra++;
        end
        chk(extra == 0, "R4 code 6 no irq", extra, 0);
        chk(changes == 0, "R4 code 6 output still", changes, 0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule